// File: doc/BRIEF.md
# Posted Write Ordering Controller

This block sits in the outbound path of a host-to-PCI bridge. Processor memory writes aimed at PCI targets are taken into an eight-entry posted queue and acknowledged at once; a drain engine then hands them, oldest first, to the PCI master side through a valid/ready port. The same block answers inbound PCI master reads of main memory. It ends each read phase with a one-cycle target ready (TRDY#) or a one-cycle disconnect (STOP# with TRDY# held high), both active low.

When the ordering enable is set and a read arrives while posted writes are still queued, the block disconnects the read. It notes how many entries were queued at that moment and raises a flush status until those entries have all left. The master's retry is disconnected again while that flush is still running. Once the flush is done, the retry gets TRDY# even if newer writes have since been queued. With the enable clear, every read gets TRDY# whatever the queue holds.

Top module: `pwo_bridge`

## Requirements
- R1: A processor write is taken on a clock edge where `cpu_wr_valid` and `cpu_wr_ready` are both high. `cpu_wr_ready` is low exactly when 8 entries are queued.
- R2: Posted writes leave on the outbound port in the order they were taken, each with the address and data it was posted with.
- R3: `out_valid` is high whenever the queue is not empty. While `out_ready` is low, `out_valid`, `out_addr` and `out_data` hold steady. Each edge with `out_valid` and `out_ready` both high removes exactly one entry.
- R4: With `cfg_order_en` high, a fresh read found with a non-empty queue is answered one cycle after the edge that samples `rd_req`. The answer is a one-cycle pulse with `stop_n` low and `trdy_n` high.
- R5: With `cfg_order_en` high, a read found with an empty queue and no pending retry is answered with a one-cycle `trdy_n` low pulse, `stop_n` staying high.
- R6: With `cfg_order_en` low, every read is answered with `trdy_n` low and never with `stop_n` low, whatever the queue holds.
- R7: After a disconnect, the retried read gets `stop_n` low again while entries queued before the disconnect remain. Once those entries are gone it gets `trdy_n` low, even if writes taken after the disconnect are still queued.
- R8: `stop_n` and `trdy_n` are never low in the same cycle. Both are high in the cycle after the answer pulse.
- R9: `flush_busy` rises together with the disconnect pulse. It stays high until the edge that pops the last entry queued before that disconnect, and it falls only on a pop.
- R10: After reset, `stop_n` and `trdy_n` are high, `out_valid` and `flush_busy` are low, and `cpu_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_order_en | input | 1 | Ordering compliance enable |
| cpu_wr_valid | input | 1 | Processor write request |
| cpu_wr_addr | input | 32 | Processor write address |
| cpu_wr_data | input | 32 | Processor write data |
| cpu_wr_ready | output | 1 | Queue can take a write |
| out_valid | output | 1 | Outbound write available |
| out_ready | input | 1 | PCI side takes the outbound write |
| out_addr | output | 32 | Outbound write address |
| out_data | output | 32 | Outbound write data |
| rd_req | input | 1 | Inbound memory read phase active |
| stop_n | output | 1 | Disconnect, active low |
| trdy_n | output | 1 | Target ready, active low |
| flush_busy | output | 1 | Ordering flush in progress |

## Verification
A wrong queue pointer or count shows up at the first pop after the fault. It appears as a wrong address or data word, or as `cpu_wr_ready` dropping at the wrong fill level. A wrong flush counter or retry flag appears on the next read's answer pulse, one cycle after `rd_req` is sampled: STOP where TRDY was due, or the reverse. It also shows as `flush_busy` falling one pop too early or too late. These states are probed one entry at a time, because off-by-one errors in the flush count show only at that granularity.

// File: rtl/pwo_pkg.sv
package pwo_pkg;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } post_entry_t;

    typedef enum logic [1:0] {RD_IDLE, RD_TERM, RD_WAIT} rd_state_e;
    typedef enum logic [1:0] {RSP_NONE, RSP_STOP, RSP_TRDY} rd_rsp_e;

    // Answer to a read sampled in the idle state.
    function automatic rd_rsp_e pick_rsp(input logic order_en, input logic retry,
                                         input logic flush_done, input logic q_empty);
        if (!order_en)      return RSP_TRDY;
        else if (retry)     return flush_done ? RSP_TRDY : RSP_STOP;
        else if (!q_empty)  return RSP_STOP;
        else                return RSP_TRDY;
    endfunction
endpackage

// File: rtl/pwo_fifo.sv
module pwo_fifo
    import pwo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  post_entry_t push_entry,
    input  logic        pop,
    output post_entry_t head,
    output logic        empty,
    output logic        full,
    output logic [CW-1:0] count
);
    post_entry_t mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW-1:0] wptr_nx, rptr_nx;

    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            assign wptr_nx = wptr + PW'(1);
            assign rptr_nx = rptr + PW'(1);
        end else begin : g_wrap
            assign wptr_nx = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
            assign rptr_nx = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    assert_fill_step_R1: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (count == $past(count) + CW'(1)));
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
endmodule

// File: rtl/pwo_drain.sv
module pwo_drain
    import pwo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  post_entry_t       head,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              pop
);
    assign out_valid = !q_empty;
    assign out_addr  = head.addr;
    assign out_data  = head.data;
    assign pop       = out_valid && out_ready;

    assert_hold_while_stalled_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
endmodule

// File: rtl/pwo_rd_ctrl.sv
module pwo_rd_ctrl
    import pwo_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          order_en,
    input  logic          rd_req,
    input  logic          q_empty,
    input  logic [CW-1:0] q_count,
    input  logic          pop,
    output logic          stop_n,
    output logic          trdy_n,
    output logic          flush_busy
);
    rd_state_e     state;
    rd_rsp_e       rsp;
    logic          retry;
    logic [CW-1:0] drain_left;

    always_comb rsp = pick_rsp(order_en, retry, drain_left == '0, q_empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RD_IDLE;
            stop_n     <= 1'b1;
            trdy_n     <= 1'b1;
            retry      <= 1'b0;
            drain_left <= '0;
        end else begin
            stop_n <= 1'b1;
            trdy_n <= 1'b1;
            if (pop && drain_left != '0) drain_left <= drain_left - CW'(1);
            case (state)
                RD_IDLE: if (rd_req) begin
                    state <= RD_TERM;
                    if (rsp == RSP_STOP) begin
                        stop_n <= 1'b0;
                        if (!retry) begin
                            retry      <= 1'b1;
                            drain_left <= q_count - CW'(pop);
                        end
                    end else begin
                        trdy_n <= 1'b0;
                        retry  <= 1'b0;
                    end
                end
                RD_TERM: state <= rd_req ? RD_WAIT : RD_IDLE;
                default: if (!rd_req) state <= RD_IDLE;
            endcase
        end
    end

    assign flush_busy = (drain_left != '0);

    assert_never_both_R8: assert property (@(posedge clk) disable iff (rst)
        !(!stop_n && !trdy_n));
    assert_pulse_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (!stop_n || !trdy_n) |=> (stop_n && trdy_n));
    assert_no_stop_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> $past(order_en));
    assert_flush_ends_on_pop_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_busy) |-> $past(pop));
endmodule

// File: rtl/pwo_bridge.sv
module pwo_bridge
    import pwo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_order_en,
    input  logic              cpu_wr_valid,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    output logic              cpu_wr_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic              rd_req,
    output logic              stop_n,
    output logic              trdy_n,
    output logic              flush_busy
);
    post_entry_t   in_entry, head;
    logic          q_empty, q_full, push, pop;
    logic [CW-1:0] q_count;

    assign in_entry     = '{addr: cpu_wr_addr, data: cpu_wr_data};
    assign cpu_wr_ready = !q_full;
    assign push         = cpu_wr_valid && cpu_wr_ready;

    pwo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_entry(in_entry), .pop(pop),
        .head(head), .empty(q_empty), .full(q_full), .count(q_count)
    );

    pwo_drain u_drain (
        .clk(clk), .rst(rst), .q_empty(q_empty), .head(head), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data), .pop(pop)
    );

    pwo_rd_ctrl #(.CW(CW)) u_rd (
        .clk(clk), .rst(rst), .order_en(cfg_order_en), .rd_req(rd_req),
        .q_empty(q_empty), .q_count(q_count), .pop(pop),
        .stop_n(stop_n), .trdy_n(trdy_n), .flush_busy(flush_busy)
    );
endmodule

// File: tb/sim_pwo_bridge.sv
module sim_pwo_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_order_en;
    logic        cpu_wr_valid;
    logic [31:0] cpu_wr_addr, cpu_wr_data;
    logic        cpu_wr_ready;
    logic        out_valid, out_ready;
    logic [31:0] out_addr, out_data;
    logic        rd_req, stop_n, trdy_n, flush_busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_addr [0:63];
    logic [31:0] m_data [0:63];
    int wr_i = 0;
    int rd_i = 0;

    always #2 clk = ~clk;

    pwo_bridge u0 (
        .clk(clk), .rst(rst), .cfg_order_en(cfg_order_en),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .cpu_wr_ready(cpu_wr_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .rd_req(rd_req),
        .stop_n(stop_n), .trdy_n(trdy_n), .flush_busy(flush_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write();
        logic [31:0] a, d;
        a = 32'h4000_0000 + 32'(wr_i) * 4;
        d = 32'hA5A5_0000 ^ (32'(wr_i) * 32'h0101_0003);
        @(negedge clk);
        cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
        @(posedge clk); #1;
        cpu_wr_valid = 1'b0;
        m_addr[wr_i] = a; m_data[wr_i] = d; wr_i++;
    endtask

    task automatic pop_one(input string req);
        @(negedge clk);
        chk(out_valid === 1'b1, req, {31'd0, out_valid}, 32'd1);
        chk(out_addr === m_addr[rd_i], req, out_addr, m_addr[rd_i]);
        chk(out_data === m_data[rd_i], req, out_data, m_data[rd_i]);
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
        rd_i++;
    endtask

    // exp_stop: 1 expects a disconnect, 0 expects target ready
    task automatic do_read(input bit exp_stop, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk); #1;
        chk(stop_n === !exp_stop, req, {31'd0, stop_n}, {31'd0, !exp_stop});
        chk(trdy_n === exp_stop, req, {31'd0, trdy_n}, {31'd0, exp_stop});
        rd_req = 1'b0;
        @(posedge clk); #1;
        chk(stop_n === 1'b1 && trdy_n === 1'b1, "R8", {30'd0, stop_n, trdy_n}, 32'd3);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_order_en = 1'b1; cpu_wr_valid = 1'b0; cpu_wr_addr = '0;
        cpu_wr_data = '0; out_ready = 1'b0; rd_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(stop_n === 1'b1 && trdy_n === 1'b1, "R10", {30'd0, stop_n, trdy_n}, 32'd3);
        chk(out_valid === 1'b0 && flush_busy === 1'b0, "R10", {30'd0, out_valid, flush_busy}, 32'd0);
        chk(cpu_wr_ready === 1'b1, "R10", {31'd0, cpu_wr_ready}, 32'd1);
    endtask

    task automatic t_fill_and_order();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(cpu_wr_ready === 1'b1, "R1", {31'd0, cpu_wr_ready}, 32'd1);
            cpu_write();
        end
        @(negedge clk);
        chk(cpu_wr_ready === 1'b0, "R1 full", {31'd0, cpu_wr_ready}, 32'd0);
        // stalled head holds for several cycles
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_addr === m_addr[rd_i] && out_data === m_data[rd_i], "R3 hold", out_addr, m_addr[rd_i]);
        pop_one("R3");
        @(negedge clk);
        chk(cpu_wr_ready === 1'b1, "R1 space", {31'd0, cpu_wr_ready}, 32'd1);
        for (int i = 0; i < 7; i++) pop_one("R2");
        @(negedge clk);
        chk(out_valid === 1'b0, "R3 empty", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_empty_read();
        cfg_order_en = 1'b1;
        do_read(1'b0, "R5");
        chk(flush_busy === 1'b0, "R5", {31'd0, flush_busy}, 32'd0);
    endtask

    task automatic t_ordered_flush();
        cfg_order_en = 1'b1;
        for (int i = 0; i < 3; i++) cpu_write();
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk); #1;
        chk(stop_n === 1'b0 && trdy_n === 1'b1, "R4", {30'd0, stop_n, trdy_n}, 32'd1);
        chk(flush_busy === 1'b1, "R9 rise", {31'd0, flush_busy}, 32'd1);
        rd_req = 1'b0;
        @(posedge clk); #1;
        chk(stop_n === 1'b1 && trdy_n === 1'b1, "R8", {30'd0, stop_n, trdy_n}, 32'd3);
        @(posedge clk); #1;
        do_read(1'b1, "R7 early retry");
        cpu_write();
        cpu_write();
        pop_one("R2");
        pop_one("R2");
        @(negedge clk);
        chk(flush_busy === 1'b1, "R9 hold", {31'd0, flush_busy}, 32'd1);
        do_read(1'b1, "R7 one left");
        pop_one("R2");
        @(negedge clk);
        chk(flush_busy === 1'b0, "R9 fall", {31'd0, flush_busy}, 32'd0);
        chk(out_valid === 1'b1, "R7 newer queued", {31'd0, out_valid}, 32'd1);
        do_read(1'b0, "R7 retry served");
        do_read(1'b1, "R4 fresh read");
        pop_one("R2");
        pop_one("R2");
        do_read(1'b0, "R7 served after drain");
    endtask

    task automatic t_compliance_off();
        cfg_order_en = 1'b0;
        for (int i = 0; i < 4; i++) cpu_write();
        do_read(1'b0, "R6");
        chk(flush_busy === 1'b0, "R6", {31'd0, flush_busy}, 32'd0);
        do_read(1'b0, "R6 again");
        for (int i = 0; i < 4; i++) pop_one("R2");
        cfg_order_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_fill_and_order();
        t_empty_read();
        t_ordered_flush();
        t_compliance_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule